// File: doc/BRIEF.md
# Suspend Duty-Cycle Throttle

This block slows a processor by driving an active-low suspend output. While the output is low the processor idles, and while it is high the processor runs. Once throttling is enabled, the output alternates between a run phase of OFF time units and a suspend phase of ON time units, and this pattern repeats. A fixed prescaler of `UNIT_DIV` clock cycles sets the length of one time unit. The default of 960 cycles at 30 MHz gives 32 µs. The effective speed is full speed × OFF / (OFF + ON).

Software programs the block through a simple write port that holds five byte registers: a control byte, the OFF count, the ON count and two speedup timer reloads. An interrupt event or a video event can pause throttling. When its enables allow, the event loads a retriggerable timer that counts in millisecond units of `MS_DIV` cycles. Throttling stays suspended until every such timer has run out. It then restarts with a fresh run phase.

Top module: `duty_throttle`

## Requirements
- R1: After synchronous reset every register is zero and `susp_n` is 1. It stays 1 until the block is programmed.
- R2: With modulation enabled and both counts nonzero, `susp_n` is 1 for OFF×UNIT_DIV cycles and then 0 for ON×UNIT_DIV cycles, repeating. After enabling from idle, the run phase comes first: the output first goes low in the cycle after edge k+1+OFF×UNIT_DIV, where k is the edge that wrote the enable.
- R3: While control bit 0 (modulation enable) is 0, `susp_n` stays 1.
- R4: A write to the ON or OFF count takes effect only at the next period boundary. The phase in progress keeps its old length.
- R5: A zero count skips its phase. With ON=0 the output stays 1. With OFF=0 it stays 0. With both zero it stays 1.
- R6: When control bits 1 (power-management enable) and 2 (interrupt speedup enable) are set, a pulse on `irq_evt` makes `susp_n` 1 from the second edge after the pulse. It stays 1 for IRQT×MS_DIV cycles, counted from the edge that samples the pulse. Throttling then restarts with a full run phase.
- R7: A new event while a speedup timer is running reloads that timer with its full value.
- R8: When control bits 1 and 3 (video speedup enable) are set, a pulse on `vid_evt` behaves like R6, with the duration taken from VIDT.
- R9: An event is ignored when its own enable bit is clear or when control bit 1 is clear.
- R10: Register addresses are 0 for control, 1 for OFF, 2 for ON, 3 for IRQT and 4 for VIDT. Writes to addresses 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| irq_evt | input | 1 | Interrupt activity pulse |
| vid_evt | input | 1 | Video activity pulse |
| susp_n | output | 1 | Active-low suspend request to the processor |

## Verification
The bench measures the length of every low run and every high run. This exposes a prescaler that is one cycle off or a phase counter that stops one unit early or late. Rewriting the ON count in the middle of a suspend phase exposes a design that truncates or merges phases instead of waiting for the period boundary. Counting the high cycles after a speedup pulse, and after a second pulse sent while the first timer is still running, exposes three faults: a timer that does not reload, a timer that runs one millisecond unit short, and a resume that skips the fresh run phase. The bench also sends pulses with the power-management bit or the per-source enable clear, and zero ON or OFF counts. This catches gating that leaks events, and a zero-length phase that produces a stray one-unit pulse.

// File: rtl/thr_pkg.sv
package thr_pkg;

   localparam int DATA_W = 8;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] ADR_OFF  = 3'd1;
   localparam logic [ADDR_W-1:0] ADR_ON   = 3'd2;
   localparam logic [ADDR_W-1:0] ADR_IRQT = 3'd3;
   localparam logic [ADDR_W-1:0] ADR_VIDT = 3'd4;

   // field order sets bit positions: mod_en is bit 0
   typedef struct packed {
      logic vid_spd;
      logic irq_spd;
      logic pm_en;
      logic mod_en;
   } ctrl_t;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RUN  = 2'd1,
      PH_SUSP = 2'd2
   } phase_e;

endpackage

// File: rtl/thr_regs.sv
module thr_regs
   import thr_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int TMR_W = 8
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          we,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [DATA_W-1:0]             wdata,
   output ctrl_t                         ctrl,
   output logic [CNT_W-1:0]              run_cnt,
   output logic [CNT_W-1:0]              susp_cnt,
   output logic [1:0][TMR_W-1:0]         tmr_val
);

   if (CNT_W > DATA_W || CNT_W < 1) begin : g_bad_cnt
      $error("thr_regs: CNT_W must lie in 1..DATA_W");
   end
   if (TMR_W > DATA_W || TMR_W < 1) begin : g_bad_tmr
      $error("thr_regs: TMR_W must lie in 1..DATA_W");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl     <= '0;
         run_cnt  <= '0;
         susp_cnt <= '0;
         tmr_val  <= '0;
      end else if (we) begin
         case (addr)
            ADR_CTRL: ctrl       <= ctrl_t'(wdata[3:0]);
            ADR_OFF:  run_cnt    <= wdata[CNT_W-1:0];
            ADR_ON:   susp_cnt   <= wdata[CNT_W-1:0];
            ADR_IRQT: tmr_val[0] <= wdata[TMR_W-1:0];
            ADR_VIDT: tmr_val[1] <= wdata[TMR_W-1:0];
            default: ;
         endcase
      end
   end

   AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
      (we && addr > ADR_VIDT) |=> ($stable(ctrl) && $stable(run_cnt) && $stable(susp_cnt) && $stable(tmr_val))) // R10
      else $error("write to unmapped address changed a register");

endmodule

// File: rtl/thr_spd_timer.sv
module thr_spd_timer #(
   parameter int TMR_W  = 8,
   parameter int MS_DIV = 30000
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             evt,
   input  logic             gate,
   input  logic [TMR_W-1:0] ld_val,
   output logic             active
);

   if (MS_DIV < 2) begin : g_bad_div
      $error("thr_spd_timer: MS_DIV must be at least 2");
   end

   localparam int SUB_W = $clog2(MS_DIV);
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(MS_DIV - 1);

   logic [TMR_W-1:0] cnt;
   logic [SUB_W-1:0] sub;
   logic             load;

   assign load   = evt && gate;
   assign active = gate && (cnt != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
         sub <= '0;
      end else if (load) begin
         cnt <= ld_val;
         sub <= '0;
      end else if (cnt != '0) begin
         if (sub == SUB_LAST) begin
            sub <= '0;
            cnt <= cnt - 1'b1;
         end else begin
            sub <= sub + 1'b1;
         end
      end
   end

   AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (rst)
      load |=> (cnt == $past(ld_val) && sub == '0)) // R7
      else $error("speedup timer did not reload");

   AST_TMR_DECAY: assert property (@(posedge clk) disable iff (rst)
      (!load && cnt != '0) |=> (cnt <= $past(cnt))) // R6
      else $error("speedup timer grew without an event");

   AST_TMR_GATED: assert property (@(posedge clk) disable iff (rst)
      (evt && !gate && cnt == '0) |=> (cnt == '0)) // R9
      else $error("gated event started the timer");

endmodule

// File: rtl/thr_modgen.sv
module thr_modgen
   import thr_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int UNIT_DIV = 960
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic [CNT_W-1:0] run_cnt,
   input  logic [CNT_W-1:0] susp_cnt,
   output logic             susp_n
);

   if (UNIT_DIV < 2) begin : g_bad_div
      $error("thr_modgen: UNIT_DIV must be at least 2");
   end

   localparam int PRE_W = $clog2(UNIT_DIV);
   localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_DIV - 1);

   phase_e           ph;
   logic [PRE_W-1:0] pre;
   logic [CNT_W-1:0] units;
   logic [CNT_W-1:0] lat_run;
   logic [CNT_W-1:0] lat_susp;
   logic [CNT_W-1:0] cur_len;
   logic             unit_tick;
   logic             phase_end;

   function automatic phase_e first_phase(logic [CNT_W-1:0] r, logic [CNT_W-1:0] s);
      if (r != '0)      return PH_RUN;
      else if (s != '0) return PH_SUSP;
      else              return PH_IDLE;
   endfunction

   assign cur_len   = (ph == PH_SUSP) ? lat_susp : lat_run;
   assign unit_tick = (pre == PRE_LAST);
   assign phase_end = (ph != PH_IDLE) && unit_tick &&
                      (({1'b0, units} + (CNT_W+1)'(1)) == {1'b0, cur_len});

   always_ff @(posedge clk) begin
      if (rst) begin
         ph       <= PH_IDLE;
         pre      <= '0;
         units    <= '0;
         lat_run  <= '0;
         lat_susp <= '0;
      end else if (!run) begin
         ph    <= PH_IDLE;
         pre   <= '0;
         units <= '0;
      end else if (ph == PH_IDLE) begin
         lat_run  <= run_cnt;
         lat_susp <= susp_cnt;
         ph       <= first_phase(run_cnt, susp_cnt);
         pre      <= '0;
         units    <= '0;
      end else begin
         pre <= unit_tick ? '0 : pre + 1'b1;
         if (phase_end) begin
            units <= '0;
            if (ph == PH_RUN && lat_susp != '0) begin
               ph <= PH_SUSP;
            end else begin
               lat_run  <= run_cnt;
               lat_susp <= susp_cnt;
               ph       <= first_phase(run_cnt, susp_cnt);
            end
         end else if (unit_tick) begin
            units <= units + 1'b1;
         end
      end
   end

   assign susp_n = (ph != PH_SUSP);

   AST_SUSP_HAS_LEN: assert property (@(posedge clk) disable iff (rst)
      (ph == PH_SUSP) |-> (lat_susp != '0)) // R5
      else $error("suspend phase entered with zero length");

   AST_UNIT_BOUND: assert property (@(posedge clk) disable iff (rst)
      (ph != PH_IDLE) |-> (units < cur_len)) // R2
      else $error("phase unit counter overran its length");

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
      (ph != PH_IDLE && !phase_end) |=> ($stable(lat_run) && $stable(lat_susp))) // R4
      else $error("counts changed inside a period");

endmodule

// File: rtl/duty_throttle.sv
module duty_throttle
   import thr_pkg::*;
#(
   parameter int UNIT_DIV = 960,
   parameter int MS_DIV   = 30000,
   parameter int CNT_W    = 8,
   parameter int TMR_W    = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   input  logic              irq_evt,
   input  logic              vid_evt,
   output logic              susp_n
);

   localparam int NSRC = 2;

   ctrl_t                  ctrl;
   logic [CNT_W-1:0]       run_cnt;
   logic [CNT_W-1:0]       susp_cnt;
   logic [NSRC-1:0][TMR_W-1:0] tmr_val;
   logic [NSRC-1:0]        src_evt;
   logic [NSRC-1:0]        src_en;
   logic [NSRC-1:0]        spd_act;
   logic                   run;

   thr_regs #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_regs (
      .clk      (clk),
      .rst      (rst),
      .we       (reg_we),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .ctrl     (ctrl),
      .run_cnt  (run_cnt),
      .susp_cnt (susp_cnt),
      .tmr_val  (tmr_val)
   );

   assign src_evt = {vid_evt, irq_evt};
   assign src_en  = {ctrl.vid_spd, ctrl.irq_spd};

   for (genvar i = 0; i < NSRC; i++) begin : g_spd
      thr_spd_timer #(.TMR_W(TMR_W), .MS_DIV(MS_DIV)) u_tmr (
         .clk    (clk),
         .rst    (rst),
         .evt    (src_evt[i]),
         .gate   (ctrl.pm_en && src_en[i]),
         .ld_val (tmr_val[i]),
         .active (spd_act[i])
      );
   end

   assign run = ctrl.mod_en && (spd_act == '0);

   thr_modgen #(.CNT_W(CNT_W), .UNIT_DIV(UNIT_DIV)) u_mod (
      .clk      (clk),
      .rst      (rst),
      .run      (run),
      .run_cnt  (run_cnt),
      .susp_cnt (susp_cnt),
      .susp_n   (susp_n)
   );

   AST_DISABLED_HIGH: assert property (@(posedge clk) disable iff (rst)
      !ctrl.mod_en |=> susp_n) // R3
      else $error("suspend asserted while modulation disabled");

   AST_SPEEDUP_HIGH: assert property (@(posedge clk) disable iff (rst)
      (spd_act != '0) |=> susp_n) // R6
      else $error("suspend asserted during speedup");

   AST_NO_SPEEDUP_NO_PM: assert property (@(posedge clk) disable iff (rst)
      !ctrl.pm_en |-> (spd_act == '0)) // R9
      else $error("speedup active without power management enable");

endmodule

// File: tb/duty_throttle_bench.sv
`timescale 1ns/1ps
module duty_throttle_bench;

   localparam int UDIV = 4;
   localparam int MDIV = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       reg_we = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       irq_evt = 1'b0;
   logic       vid_evt = 1'b0;
   logic       susp_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   duty_throttle #(.UNIT_DIV(UDIV), .MS_DIV(MDIV)) u_duty_throttle (
      .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .irq_evt(irq_evt), .vid_evt(vid_evt), .susp_n(susp_n)
   );

   function automatic int exp_len(int cnt);
      return cnt * UDIV;
   endfunction

   function automatic int exp_speedup(int tmr, int off);
      return tmr * MDIV + off * UDIV;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic wait_fall();
      bit prev;
      prev = susp_n;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (prev && !susp_n) return;
         prev = susp_n;
      end
   endtask

   task automatic count_low(output int n);
      n = 0;
      while (!susp_n && n < 5000) begin n++; @(negedge clk); end
   endtask

   task automatic count_high(output int n);
      n = 0;
      while (susp_n && n < 5000) begin n++; @(negedge clk); end
   endtask

   task automatic measure(output int lo, output int hi);
      wait_fall();
      count_low(lo);
      count_high(hi);
   endtask

   task automatic steady(logic level, int win, output int same);
      same = 0;
      for (int i = 0; i < win; i++) begin
         @(negedge clk);
         if (susp_n == level) same++;
      end
   endtask

   task automatic speedup_pulse(bit vid);
      if (vid) vid_evt = 1'b1; else irq_evt = 1'b1;
      @(negedge clk);
      vid_evt = 1'b0; irq_evt = 1'b0;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      int lo, hi, n, on_v, off_v;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(susp_n == 1'b1, "R1 reset level", int'(susp_n), 1);
      steady(1'b1, 50, n);
      check(n == 50, "R1 idle after reset", n, 50);

      // R3: counts set, modulation disabled
      wr(3'd1, 8'd2); wr(3'd2, 8'd3);
      steady(1'b1, 100, n);
      check(n == 100, "R3 disabled stays high", n, 100);

      // R2: random duty patterns, run phase first after enable
      for (int it = 0; it < 6; it++) begin
         on_v  = 1 + int'($urandom % 10);
         off_v = 1 + int'($urandom % 10);
         wr(3'd0, 8'h00);
         wr(3'd2, 8'(on_v));
         wr(3'd1, 8'(off_v));
         wr(3'd0, 8'h01);
         count_high(n);
         check(n == exp_len(off_v) + 1, "R2 first run phase", n, exp_len(off_v) + 1);
         measure(lo, hi);
         check(lo == exp_len(on_v), "R2 suspend length", lo, exp_len(on_v));
         check(hi == exp_len(off_v), "R2 run length", hi, exp_len(off_v));
      end

      // R4: mid-phase write of ON count
      wr(3'd0, 8'h00); wr(3'd2, 8'd4); wr(3'd1, 8'd3); wr(3'd0, 8'h01);
      wait_fall();
      reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 8'd2;
      @(negedge clk);
      reg_we = 1'b0;
      count_low(n);
      check(n + 1 == exp_len(4), "R4 current phase keeps old length", n + 1, exp_len(4));
      count_high(hi);
      check(hi == exp_len(3), "R4 run phase", hi, exp_len(3));
      count_low(lo);
      check(lo == exp_len(2), "R4 new length at boundary", lo, exp_len(2));

      // R10: unmapped writes ignored
      wr(3'd5, 8'hFF); wr(3'd7, 8'h00); wr(3'd6, 8'h00);
      measure(lo, hi);
      check(lo == exp_len(2) && hi == exp_len(3), "R10 unmapped write ignored", lo, exp_len(2));

      // R6: interrupt speedup
      wr(3'd3, 8'd5);
      wr(3'd0, 8'h07);
      wait_fall();
      speedup_pulse(1'b0);
      count_high(n);
      check(n == exp_speedup(5, 3), "R6 irq speedup window", n, exp_speedup(5, 3));
      count_low(lo);
      check(lo == exp_len(2), "R6 resumes full suspend phase", lo, exp_len(2));

      // R7: retrigger reloads
      wait_fall();
      irq_evt = 1'b1; @(negedge clk); irq_evt = 1'b0;
      repeat (20) @(negedge clk);
      speedup_pulse(1'b0);
      count_high(n);
      check(n == exp_speedup(5, 3), "R7 retrigger reload", n, exp_speedup(5, 3));

      // R8: video speedup
      wr(3'd4, 8'd3);
      wr(3'd0, 8'h0B);
      wait_fall();
      speedup_pulse(1'b1);
      count_high(n);
      check(n == exp_speedup(3, 3), "R8 video speedup window", n, exp_speedup(3, 3));

      // R9: gating without power management / per-source enable
      wr(3'd0, 8'h05);
      wait_fall();
      irq_evt = 1'b1; @(negedge clk); irq_evt = 1'b0;
      count_low(n);
      check(n + 1 == exp_len(2), "R9 irq ignored without pm", n + 1, exp_len(2));
      wr(3'd0, 8'h03);
      wait_fall();
      vid_evt = 1'b1; @(negedge clk); vid_evt = 1'b0;
      count_low(n);
      check(n + 1 == exp_len(2), "R9 vid ignored without its enable", n + 1, exp_len(2));

      // R5: zero counts
      wr(3'd1, 8'd0);
      repeat (60) @(negedge clk);
      steady(1'b0, 200, n);
      check(n == 200, "R5 OFF zero stays low", n, 200);
      wr(3'd2, 8'd0); wr(3'd1, 8'd3);
      repeat (60) @(negedge clk);
      steady(1'b1, 200, n);
      check(n == 200, "R5 ON zero stays high", n, 200);
      wr(3'd1, 8'd0);
      repeat (20) @(negedge clk);
      steady(1'b1, 200, n);
      check(n == 200, "R5 both zero stays high", n, 200);

      // R3: clearing enable mid-run
      wr(3'd2, 8'd3); wr(3'd1, 8'd1);
      wait_fall();
      wr(3'd0, 8'h00);
      steady(1'b1, 100, n);
      check(n == 100, "R3 disable forces high", n, 100);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule